// File: doc/BRIEF.md
# Serial camera stream sync decoder

This block sits behind a serial camera link receiver and runs on the recovered bit clock. One data bit arrives on each rising edge, least significant bit first within each byte. The block turns the stream into bytes and emits each byte on a parallel output with a one-cycle strobe, so the strobe comes at one eighth of the bit rate.

The stream carries four 32-bit markers made of an all-ones byte, two zero bytes and a type byte. They mark the start and end of each frame and the start and end of each line. When any of these markers is seen, at any bit offset, the byte boundary is moved so that the marker sits on byte boundaries.

In sync mode the markers drive a level-style frame sync and line sync output, and the marker bytes are kept off the parallel output. In pass-through mode both sync outputs stay low and every byte, markers included, is forwarded. The bit clock may run freely or be stopped between lines. A clock edge always counts as exactly one bit.

Top module: `cam_sync_deser`

## Requirements
- R1: Bits are assembled least significant bit first. When no marker is found, a byte event occurs on every eighth bit counted from enable. At each byte event that is not suppressed, `byte_stb` is high for one cycle, starting the cycle after the edge that sampled the last bit. `byte_out` then shows the byte whose last bit arrived 24 bits before that edge. `byte_out` holds its value between strobes.
- R2: With `sync_mode` low, every byte event gives a strobe, marker bytes included.
- R3: A marker is bytes FF, 00, 00, T in arrival order, with T in 00..03. It is recognised at any bit offset. The bit that completes it is a byte event, and the next byte events follow every eighth bit after it.
- R4: With `sync_mode` high, T=00 sets `line_sync` high and T=01 sets it low. The change is visible the cycle after the marker's last bit.
- R5: With `sync_mode` high, T=02 sets `frame_sync` high and T=03 sets it low. The change is visible the cycle after the marker's last bit.
- R6: With `sync_mode` high, none of the four bytes of a recognised marker is strobed. All other bytes are.
- R7: A sequence FF, 00, 00, T with T above 03 is not a marker. Its bytes are strobed as data, and neither sync output changes.
- R8: While `sync_mode` is low, `frame_sync` and `line_sync` are low from the next cycle on.
- R9: While `en` is low, or `rst` is high, the next cycle shows all outputs at zero and the bit history and byte phase cleared. After `en` rises, the byte phase starts again at the first bit.
- R10: While the bit clock is stopped, no output changes, and decoding continues correctly when the clock resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock, free-running or gated |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Decoder enable, low clears and silences the block |
| sync_mode | input | 1 | High: decode markers and strip them; low: pass-through |
| ser_in | input | 1 | Serial data bit, sampled on the rising edge |
| byte_out | output | BYTE_W | Parallel output byte |
| byte_stb | output | 1 | One-cycle strobe marking a new byte on `byte_out` |
| frame_sync | output | 1 | Frame sync level |
| line_sync | output | 1 | Line sync level |

## Verification
A byte phase that is off by even one bit shows up as a wrong value at the very next strobe. Missing realignment on a marker shows up as a wrong byte within eight bits of the marker's end. A suppression counter that is wrong shows up as a missing strobe or an extra strobe within the four byte events after a marker. A wrong sync state shows up on the sync outputs in the cycle after the marker's last bit. The bench therefore compares every output on every clock against a bit-queue model, and it adds targeted checks that count strobes around valid markers, around invalid markers, around a stopped clock and around re-enable.

// File: rtl/cam_sync_pkg.sv
package cam_sync_pkg;
  // Marker type held in the low two bits of the fourth marker byte
  typedef enum logic [1:0] {
    MK_LINE_ON   = 2'd0,
    MK_LINE_OFF  = 2'd1,
    MK_FRAME_ON  = 2'd2,
    MK_FRAME_OFF = 2'd3
  } marker_kind_e;
endpackage

// File: rtl/cam_bit_window.sv
// Sliding history of the most recent WIN_BYTES*BYTE_W bits.
// The newest bit enters at the top, so the oldest byte sits in the low bits.
module cam_bit_window #(
  parameter int BYTE_W    = 8,
  parameter int WIN_BYTES = 4,
  localparam int WIN_W    = BYTE_W * WIN_BYTES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             bit_in,
  output logic [WIN_W-1:0] win_next
);
  logic [WIN_W-1:0] win_q;

  assign win_next = {bit_in, win_q[WIN_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst || clr) win_q <= '0;
    else            win_q <= win_next;
  end
endmodule

// File: rtl/cam_marker_match.sv
// Recognises the lead byte, the zero filler bytes and a valid type byte.
module cam_marker_match
  import cam_sync_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int WIN_BYTES = 4,
  localparam int WIN_W    = BYTE_W * WIN_BYTES,
  localparam int MIDS     = WIN_BYTES - 2
) (
  input  logic [WIN_W-1:0] win,
  output logic             hit,
  output marker_kind_e     kind
);
  logic [MIDS-1:0]   mid_zero;
  logic [BYTE_W-1:0] lead_b;
  logic [BYTE_W-1:0] type_b;

  assign lead_b = win[BYTE_W-1:0];
  assign type_b = win[WIN_W-1 -: BYTE_W];

  for (genvar g = 0; g < MIDS; g++) begin : g_mid
    assign mid_zero[g] = (win[(g+1)*BYTE_W +: BYTE_W] == '0);
  end

  assign hit  = (&lead_b) && (&mid_zero) && (type_b[BYTE_W-1:2] == '0);
  assign kind = marker_kind_e'(type_b[1:0]);
endmodule

// File: rtl/cam_byte_framer.sv
// Byte phase, marker-byte suppression and the registered parallel output.
module cam_byte_framer #(
  parameter int BYTE_W    = 8,
  parameter int WIN_BYTES = 4,
  localparam int WIN_W    = BYTE_W * WIN_BYTES,
  localparam int PH_W     = $clog2(BYTE_W),
  localparam int KW       = $clog2(WIN_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              mode,
  input  logic              hit,
  input  logic [WIN_W-1:0]  win,
  output logic [BYTE_W-1:0] byte_q,
  output logic              stb_q
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(BYTE_W - 1);
  localparam logic [KW-1:0]   KILL_N  = KW'(WIN_BYTES - 1);

  logic [PH_W-1:0] ph_q;
  logic [KW-1:0]   kill_q;
  logic            evt;

  assign evt = hit || (ph_q == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ph_q   <= '0;
      kill_q <= '0;
      byte_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (evt) begin
        ph_q <= '0;
        if (mode && hit)              kill_q <= KILL_N;
        else if (mode && kill_q != 0) kill_q <= kill_q - 1'b1;
        else begin
          stb_q  <= 1'b1;
          byte_q <= win[BYTE_W-1:0];
        end
      end else begin
        ph_q <= ph_q + 1'b1;
      end
      if (!mode) kill_q <= '0;
    end
  end
endmodule

// File: rtl/cam_sync_tracker.sv
// Frame and line sync levels driven by recognised markers.
module cam_sync_tracker
  import cam_sync_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         mode,
  input  logic         hit,
  input  marker_kind_e kind,
  output logic         frame_q,
  output logic         line_q
);
  always_ff @(posedge clk) begin
    if (rst || clr || !mode) begin
      frame_q <= 1'b0;
      line_q  <= 1'b0;
    end else if (hit) begin
      case (kind)
        MK_LINE_ON:   line_q  <= 1'b1;
        MK_LINE_OFF:  line_q  <= 1'b0;
        MK_FRAME_ON:  frame_q <= 1'b1;
        MK_FRAME_OFF: frame_q <= 1'b0;
        default:      ;
      endcase
    end
  end
endmodule

// File: rtl/cam_sync_deser.sv
module cam_sync_deser
  import cam_sync_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int WIN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              sync_mode,
  input  logic              ser_in,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_stb,
  output logic              frame_sync,
  output logic              line_sync
);
  localparam int WIN_W = BYTE_W * WIN_BYTES;

  logic [WIN_W-1:0] win;
  logic             hit;
  marker_kind_e     kind;
  logic             clr;

  assign clr = !en;

  cam_bit_window #(.BYTE_W(BYTE_W), .WIN_BYTES(WIN_BYTES)) u_window (
    .clk(clk), .rst(rst), .clr(clr), .bit_in(ser_in), .win_next(win)
  );

  cam_marker_match #(.BYTE_W(BYTE_W), .WIN_BYTES(WIN_BYTES)) u_match (
    .win(win), .hit(hit), .kind(kind)
  );

  cam_byte_framer #(.BYTE_W(BYTE_W), .WIN_BYTES(WIN_BYTES)) u_framer (
    .clk(clk), .rst(rst), .clr(clr), .mode(sync_mode), .hit(hit),
    .win(win), .byte_q(byte_out), .stb_q(byte_stb)
  );

  cam_sync_tracker u_tracker (
    .clk(clk), .rst(rst), .clr(clr), .mode(sync_mode), .hit(hit),
    .kind(kind), .frame_q(frame_sync), .line_q(line_sync)
  );
endmodule

// File: rtl/cam_sync_deser_chk.sv
module cam_sync_deser_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              sync_mode,
  input logic [BYTE_W-1:0] byte_out,
  input logic              byte_stb,
  input logic              frame_sync,
  input logic              line_sync
);
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!byte_stb && byte_out == '0 && !frame_sync && !line_sync)); // R9

  AST_PASS_SYNCS_LOW: assert property (@(posedge clk) disable iff (rst)
    !sync_mode |=> (!frame_sync && !line_sync)); // R8

  AST_FRAME_ON_NO_STB: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_sync) |-> !byte_stb); // R6

  AST_LINE_ON_NO_STB: assert property (@(posedge clk) disable iff (rst)
    $rose(line_sync) |-> !byte_stb); // R6

  AST_FRAME_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_sync) |-> ($past(sync_mode) && $past(en))); // R5

  AST_LINE_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
    $rose(line_sync) |-> ($past(sync_mode) && $past(en))); // R4
endmodule

bind cam_sync_deser cam_sync_deser_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .sync_mode(sync_mode), .byte_out(byte_out),
  .byte_stb(byte_stb), .frame_sync(frame_sync), .line_sync(line_sync)
);

// File: tb/test_cam_sync_deser.sv
module test_cam_sync_deser;
  logic clk = 1'b0;
  logic gate = 1'b1;
  logic gclk;
  logic rst = 1'b1, en = 1'b0, sync_mode = 1'b0, ser_in = 1'b0;
  logic [7:0] byte_out;
  logic byte_stb, frame_sync, line_sync;

  always #4 clk = ~clk;
  assign gclk = clk & gate;

  cam_sync_deser i_cam_sync_deser (
    .clk(gclk), .rst(rst), .en(en), .sync_mode(sync_mode), .ser_in(ser_in),
    .byte_out(byte_out), .byte_stb(byte_stb), .frame_sync(frame_sync),
    .line_sync(line_sync)
  );

  int n_chk = 0, n_fail = 0, stb_cnt = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural model: queue of the last 32 bits, oldest first
  bit mq[$];
  int mph, mkill;
  logic m_stb, m_fs, m_ls;
  logic [7:0] m_byte;

  function automatic logic [7:0] qbyte(int i);
    logic [7:0] r;
    for (int j = 0; j < 8; j++) r[j] = mq[8*i+j];
    return r;
  endfunction

  task automatic model_clear();
    mq.delete();
    for (int i = 0; i < 32; i++) mq.push_back(1'b0);
    mph = 0; mkill = 0; m_stb = 0; m_byte = 0; m_fs = 0; m_ls = 0;
  endtask

  task automatic model_step(bit b);
    bit match;
    logic [7:0] t;
    if (rst || !en) begin model_clear(); return; end
    mq.push_back(b);
    void'(mq.pop_front());
    t = qbyte(3);
    match = (qbyte(0) == 8'hFF) && (qbyte(1) == 8'h00) && (qbyte(2) == 8'h00) && (t <= 8'h03);
    mph++;
    m_stb = 0;
    if (match || mph == 8) begin
      mph = 0;
      if (sync_mode && match) begin
        mkill = 3;
        if (t == 8'h00) m_ls = 1;
        else if (t == 8'h01) m_ls = 0;
        else if (t == 8'h02) m_fs = 1;
        else m_fs = 0;
      end else if (sync_mode && mkill > 0) mkill--;
      else begin m_stb = 1; m_byte = qbyte(0); end
    end
    if (!sync_mode) begin mkill = 0; m_fs = 0; m_ls = 0; end
  endtask

  task automatic expect_val(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    expect_val(cur_req, "byte_stb", byte_stb, m_stb);
    expect_val(cur_req, "byte_out", byte_out, m_byte);
    expect_val("R5", "frame_sync", frame_sync, m_fs);
    expect_val("R4", "line_sync", line_sync, m_ls);
    if (byte_stb) stb_cnt++;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic send_bit(bit b);
    ser_in = b;
    @(posedge clk);
    if (gate) model_step(b);
    @(negedge clk);
    compare();
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic send_marker(logic [7:0] t);
    send_byte(8'hFF); send_byte(8'h00); send_byte(8'h00); send_byte(t);
  endtask

  initial begin
    model_clear();
    @(negedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R9";
    expect_val("R9", "reset byte_out", byte_out, 0);
    expect_val("R9", "reset byte_stb", byte_stb, 0);
    expect_val("R9", "reset frame_sync", frame_sync, 0);
    expect_val("R9", "reset line_sync", line_sync, 0);

    // pass-through, misaligned by three bits (R2, R3)
    en = 1'b1; sync_mode = 1'b0; cur_req = "R2";
    send_bit(1); send_bit(0); send_bit(1);
    send_marker(8'h02);
    stb_cnt = 0;
    repeat (4) send_byte(8'hA5);
    expect_val("R2", "strobes after marker in pass-through", stb_cnt, 4);
    expect_val("R3", "realigned byte", byte_out, 8'hA5);
    expect_val("R8", "frame_sync in pass-through", frame_sync, 0);
    send_marker(8'h00);
    expect_val("R8", "line_sync in pass-through", line_sync, 0);
    repeat (4) send_byte(8'h01);
    expect_val("R1", "lsb-first byte", byte_out, 8'h01);

    // sync mode (R4, R5, R6, R7)
    sync_mode = 1'b1; cur_req = "R6";
    repeat (3) send_byte(8'h11);
    send_marker(8'h02);
    expect_val("R5", "frame start", frame_sync, 1);
    stb_cnt = 0;
    repeat (4) send_byte(8'h3C);
    expect_val("R6", "strobes after marker in sync mode", stb_cnt, 1);
    expect_val("R6", "first payload byte", byte_out, 8'h3C);
    send_marker(8'h00);
    expect_val("R4", "line start", line_sync, 1);
    repeat (5) send_byte(8'h5A);
    send_marker(8'h01);
    expect_val("R4", "line end", line_sync, 0);
    repeat (4) send_byte(8'h77);
    cur_req = "R7";
    send_marker(8'h07);
    stb_cnt = 0;
    repeat (4) send_byte(8'h66);
    expect_val("R7", "strobes after invalid marker", stb_cnt, 4);
    expect_val("R7", "frame_sync kept", frame_sync, 1);
    expect_val("R7", "line_sync kept", line_sync, 0);
    send_marker(8'h03);
    expect_val("R5", "frame end", frame_sync, 0);

    // gated clock (R10)
    cur_req = "R10";
    send_bit(1); send_bit(1); send_bit(0); send_bit(1);
    gate = 1'b0;
    repeat (6) begin @(posedge clk); @(negedge clk); compare(); end
    gate = 1'b1;
    send_bit(0); send_bit(0); send_bit(1); send_bit(0);
    send_marker(8'h00);
    expect_val("R10", "line start after clock gap", line_sync, 1);
    repeat (4) send_byte(8'hC3);
    expect_val("R10", "payload after clock gap", byte_out, 8'hC3);

    // disable and restart (R9, R1)
    cur_req = "R9";
    en = 1'b0;
    send_bit(1);
    expect_val("R9", "disabled byte_out", byte_out, 0);
    expect_val("R9", "disabled line_sync", line_sync, 0);
    en = 1'b1; sync_mode = 1'b0; cur_req = "R1";
    stb_cnt = 0;
    repeat (7) send_bit(1);
    expect_val("R1", "no strobe before eighth bit", stb_cnt, 0);
    send_bit(1);
    expect_val("R1", "strobe on eighth bit", stb_cnt, 1);

    // long mixed run against the model
    cur_req = "R1";
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 19);
      if (r == 0) sync_mode = ~sync_mode;
      if (r == 1) send_marker(8'($urandom_range(0, 5)));
      else send_byte(8'($urandom));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule